// File: doc/BRIEF.md
# SPI Slave Hold/Pause Controller

This block sits between the pins of an SPI slave and its protocol engine. It provides the pause function driven by an active-low hold input. The serial clock, chip select, hold and serial data inputs pass through two-stage synchronisers into the system clock domain. From the synchronised values the block derives capture and drive clock-enables for the engine. It also drives the serial-output enable and a paused flag. While paused, the engine's bit counter and partially shifted word are frozen.

Hold takes effect only while the serial clock is low, in both directions. A hold edge that arrives while the clock is high is deferred until the clock next goes low. Raising chip select during a pause does not resume the transfer: it aborts it, clearing the pause and all transaction state. The block holds a small receive front end (bit counter and shift register) so that the freeze and clear behaviour can be observed at its ports. After reset the block stays disarmed until chip select has been seen high, so that the first transaction always starts from a genuine falling edge of chip select.

Top module: `spi_pause_ctrl`

## Requirements
- R1: A pause can begin only while chip select (`csn_i`, active low) is low; hold low while deselected has no effect on `paused_o`, `sdo_oe_o` or `bit_cnt_o`.
- R2: While selected, the pause begins when the synchronised hold (`holdn_i`, active low) is 0 and the synchronised serial clock is 0. If hold falls while the clock is 1, entry waits until the clock is 0.
- R3: The pause ends when the synchronised hold is 1 and the synchronised serial clock is 0. If hold rises while the clock is 1, the exit waits until the clock is 0.
- R4: While paused, `sdo_oe_o` is 0, and serial clock edges produce no `cap_ce_o` or `drv_ce_o` pulse and do not shift data in.
- R5: `bit_cnt_o` and the partially received word are kept across a pause, so the transfer continues from the same bit after the exit.
- R6: Raising chip select during a pause clears the pause and resets the bit counter and partial word to 0. No `pause_exit_o` pulse and no `rx_vld_o` pulse are produced.
- R7: While selected and not paused, each rising serial clock edge shifts `sdi_i` in MSB first and advances `bit_cnt_o`. After `WORD_W` bits, `rx_word_o` takes the word, `rx_vld_o` pulses for one cycle and the counter wraps to 0.
- R8: After reset the block ignores chip select until it has been seen high. Chip select held low through reset leaves `sdo_oe_o` at 0 and captures nothing.
- R9: `pause_enter_o` and `pause_exit_o` are single-cycle pulses, one per pause entry and one per hold-release exit.
- R10: While selected and not paused, each falling serial clock edge produces one `drv_ce_o` pulse for the output shifter.
- R11: Coming out of reset, `paused_o`, `sdo_oe_o`, `bit_cnt_o` and `rx_word_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock pin level |
| csn_i | input | 1 | Chip select, active low |
| holdn_i | input | 1 | Hold request, active low |
| sdi_i | input | 1 | Serial data in |
| paused_o | output | 1 | Pause in effect |
| sdo_oe_o | output | 1 | Serial output enable (0 = high impedance) |
| cap_ce_o | output | 1 | Capture clock-enable, one pulse per counted rising edge |
| drv_ce_o | output | 1 | Drive clock-enable, one pulse per falling edge while active |
| xact_clr_o | output | 1 | Pulse when chip select ends a transaction |
| pause_enter_o | output | 1 | Pulse on pause entry |
| pause_exit_o | output | 1 | Pulse on pause exit by hold release |
| bit_cnt_o | output | CNT_W | Bits received in the current word |
| rx_word_o | output | WORD_W | Last complete received word |
| rx_vld_o | output | 1 | Pulse when a word completes |

## Verification
The bound checker watches every cycle for the following. A pause must begin only when chip select, hold and the clock were all low in the cycle before, and it must end only on a low clock with hold high or on a deselect. No capture enable or output enable may appear while paused, and the bit count must stay frozen through a pause. A deselect during a pause must leave the counter at zero, and no output may be enabled before chip select has been seen high after reset. The bench scenarios cover the rest. Deferral of entry and exit while the clock is high shows only in bench timing. So does the MSB-first assembly of a word across a pause, the loss of the partial word on an abort, and the exact counts of entry, exit and enable pulses.

// File: rtl/spi_pause_pkg.sv
package spi_pause_pkg;
  typedef enum logic [1:0] {
    ST_ARM    = 2'd0,
    ST_IDLE   = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_PAUSED = 2'd3
  } pause_st_e;

  // bit positions inside the synchronised input bus
  localparam int unsigned PIN_SCK  = 0;
  localparam int unsigned PIN_CSN  = 1;
  localparam int unsigned PIN_HOLD = 2;
  localparam int unsigned PIN_SDI  = 3;
  localparam int unsigned PIN_N    = 4;
endpackage

// File: rtl/spi_pause_sync.sv
module spi_pause_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '0;
      else         chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_pause_edge.sv
module spi_pause_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/spi_pause_fsm.sv
module spi_pause_fsm
  import spi_pause_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic holdn_i,
  input  logic sck_rise_i,
  input  logic sck_fall_i,
  output logic paused_o,
  output logic active_o,
  output logic clr_o,
  output logic cap_ce_o,
  output logic drv_ce_o,
  output logic enter_o,
  output logic exit_o
);
  pause_st_e st_q, st_d;
  logic      selected;
  logic      hold_ok;
  logic      rel_ok;

  assign selected = (st_q == ST_ACTIVE) || (st_q == ST_PAUSED);
  assign hold_ok  = ~holdn_i & ~sck_i;
  assign rel_ok   = holdn_i & ~sck_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_ARM:    if (csn_i)  st_d = ST_IDLE;
      ST_IDLE:   if (!csn_i) st_d = ST_ACTIVE;
      ST_ACTIVE: begin
        if (csn_i)        st_d = ST_IDLE;
        else if (hold_ok) st_d = ST_PAUSED;
      end
      ST_PAUSED: begin
        if (csn_i)       st_d = ST_IDLE;
        else if (rel_ok) st_d = ST_ACTIVE;
      end
      default: st_d = ST_ARM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_ARM;
    else         st_q <= st_d;
  end

  assign paused_o = (st_q == ST_PAUSED);
  assign active_o = (st_q == ST_ACTIVE);
  // transaction reset: deselect seen, or not selected at all
  assign clr_o    = ~selected | csn_i;
  assign cap_ce_o = active_o & ~csn_i & sck_rise_i;
  assign drv_ce_o = active_o & ~csn_i & sck_fall_i;
  assign enter_o  = active_o & ~csn_i & hold_ok;
  assign exit_o   = paused_o & ~csn_i & rel_ok;
endmodule

// File: rtl/spi_pause_shift.sv
module spi_pause_shift #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ce_i,
  input  logic              sdi_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [WORD_W-1:0] word_o,
  output logic              vld_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] word_q;
  logic              vld_q;
  logic [WORD_W-1:0] sh_nx;

  assign sh_nx = {sh_q[WORD_W-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
        sh_q  <= '0;
      end else if (ce_i) begin
        sh_q <= sh_nx;
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          word_q <= sh_nx;
          vld_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign word_o = word_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/spi_pause_ctrl.sv
module spi_pause_ctrl #(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              holdn_i,
  input  logic              sdi_i,
  output logic              paused_o,
  output logic              sdo_oe_o,
  output logic              cap_ce_o,
  output logic              drv_ce_o,
  output logic              xact_clr_o,
  output logic              pause_enter_o,
  output logic              pause_exit_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_vld_o
);
  import spi_pause_pkg::*;

  logic [PIN_N-1:0] pins_raw;
  logic [PIN_N-1:0] pins_s;
  logic s_sck, s_csn, s_holdn, s_sdi;
  logic sck_rise, sck_fall;
  logic active, clr;

  assign pins_raw[PIN_SCK]  = sck_i;
  assign pins_raw[PIN_CSN]  = csn_i;
  assign pins_raw[PIN_HOLD] = holdn_i;
  assign pins_raw[PIN_SDI]  = sdi_i;

  spi_pause_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_s)
  );

  assign s_sck   = pins_s[PIN_SCK];
  assign s_csn   = pins_s[PIN_CSN];
  assign s_holdn = pins_s[PIN_HOLD];
  assign s_sdi   = pins_s[PIN_SDI];

  spi_pause_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (s_sck),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  spi_pause_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (s_sck),
    .csn_i      (s_csn),
    .holdn_i    (s_holdn),
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .paused_o   (paused_o),
    .active_o   (active),
    .clr_o      (clr),
    .cap_ce_o   (cap_ce_o),
    .drv_ce_o   (drv_ce_o),
    .enter_o    (pause_enter_o),
    .exit_o     (pause_exit_o)
  );

  spi_pause_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .ce_i   (cap_ce_o),
    .sdi_i  (s_sdi),
    .cnt_o  (bit_cnt_o),
    .word_o (rx_word_o),
    .vld_o  (rx_vld_o)
  );

  assign sdo_oe_o   = active;
  assign xact_clr_o = clr & (active | paused_o);
endmodule

// File: rtl/spi_pause_ctrl_chk.sv
module spi_pause_ctrl_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             s_csn,
  input logic             s_holdn,
  input logic             s_sck,
  input logic             paused_o,
  input logic             sdo_oe_o,
  input logic             cap_ce_o,
  input logic             pause_enter_o,
  input logic             pause_exit_o,
  input logic [CNT_W-1:0] bit_cnt_o
);
  logic seen_high;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seen_high <= 1'b0;
    else if (s_csn) seen_high <= 1'b1;
  end

  // R1
  sel_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(paused_o) |-> $past(!s_csn));
  // R2
  enter_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(paused_o) |-> $past(!s_holdn && !s_sck));
  // R3
  exit_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(paused_o) |-> $past(s_csn || (s_holdn && !s_sck)));
  // R4
  quiet_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> (!sdo_oe_o && !cap_ce_o));
  // R5
  cnt_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_o && $past(paused_o)) |-> $stable(bit_cnt_o));
  // R6
  abort_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_o && s_csn) |=> (!paused_o && bit_cnt_o == '0 && !$past(pause_exit_o)));
  // R8
  armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> seen_high);
  // R9
  enter_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_enter_o |=> (paused_o && !pause_enter_o));
  // R9
  exit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_exit_o |=> (!paused_o && !pause_exit_o));
endmodule

bind spi_pause_ctrl spi_pause_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .s_csn         (s_csn),
  .s_holdn       (s_holdn),
  .s_sck         (s_sck),
  .paused_o      (paused_o),
  .sdo_oe_o      (sdo_oe_o),
  .cap_ce_o      (cap_ce_o),
  .pause_enter_o (pause_enter_o),
  .pause_exit_o  (pause_exit_o),
  .bit_cnt_o     (bit_cnt_o)
);

// File: tb/spi_pause_ctrl_tb.sv
module spi_pause_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int WORD_W = 8;
  localparam int CNT_W  = 3;
  localparam int NVEC   = 34;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0, csn = 1'b1, holdn = 1'b1, sdi = 1'b0;
  logic paused, oe, cap_ce, drv_ce, xclr, p_in, p_out, vld;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] word;

  int checks = 0, failures = 0;
  int n_enter = 0, n_exit = 0, n_vld = 0, n_cap = 0, n_drv = 0, n_long = 0;
  logic pin_q = 1'b0, pout_q = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spi_pause_ctrl #(.WORD_W(WORD_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .csn_i(csn), .holdn_i(holdn),
    .sdi_i(sdi), .paused_o(paused), .sdo_oe_o(oe), .cap_ce_o(cap_ce),
    .drv_ce_o(drv_ce), .xact_clr_o(xclr), .pause_enter_o(p_in),
    .pause_exit_o(p_out), .bit_cnt_o(cnt), .rx_word_o(word), .rx_vld_o(vld)
  );

  always @(negedge clk) begin
    if (rst_ni) begin
      if (p_in)   n_enter++;
      if (p_out)  n_exit++;
      if (vld)    n_vld++;
      if (cap_ce) n_cap++;
      if (drv_ce) n_drv++;
      if ((p_in && pin_q) || (p_out && pout_q)) n_long++;
    end
    pin_q  <= p_in;
    pout_q <= p_out;
  end

  // {csn, holdn, sck, sdi, exp_paused, exp_oe, exp_cnt[2:0], exp_word[7:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    {4'b1100, 2'b00, 3'd0, 8'h00},
    {4'b0101, 2'b01, 3'd0, 8'h00},
    {4'b0111, 2'b01, 3'd1, 8'h00},
    {4'b0100, 2'b01, 3'd1, 8'h00},
    {4'b0110, 2'b01, 3'd2, 8'h00},
    {4'b0101, 2'b01, 3'd2, 8'h00},
    {4'b0111, 2'b01, 3'd3, 8'h00},
    {4'b0011, 2'b01, 3'd3, 8'h00},
    {4'b0001, 2'b10, 3'd3, 8'h00},
    {4'b0010, 2'b10, 3'd3, 8'h00},
    {4'b0000, 2'b10, 3'd3, 8'h00},
    {4'b0010, 2'b10, 3'd3, 8'h00},
    {4'b0110, 2'b10, 3'd3, 8'h00},
    {4'b0100, 2'b01, 3'd3, 8'h00},
    {4'b0111, 2'b01, 3'd4, 8'h00},
    {4'b0101, 2'b01, 3'd4, 8'h00},
    {4'b0110, 2'b01, 3'd5, 8'h00},
    {4'b0100, 2'b01, 3'd5, 8'h00},
    {4'b0111, 2'b01, 3'd6, 8'h00},
    {4'b0101, 2'b01, 3'd6, 8'h00},
    {4'b0111, 2'b01, 3'd7, 8'h00},
    {4'b0100, 2'b01, 3'd7, 8'h00},
    {4'b0110, 2'b01, 3'd0, 8'hB6},
    {4'b0100, 2'b01, 3'd0, 8'hB6},
    {4'b0000, 2'b10, 3'd0, 8'hB6},
    {4'b0100, 2'b01, 3'd0, 8'hB6},
    {4'b0111, 2'b01, 3'd1, 8'hB6},
    {4'b0101, 2'b01, 3'd1, 8'hB6},
    {4'b0001, 2'b10, 3'd1, 8'hB6},
    {4'b1001, 2'b00, 3'd0, 8'hB6},
    {4'b1100, 2'b00, 3'd0, 8'hB6},
    {4'b0100, 2'b01, 3'd0, 8'hB6},
    {4'b0111, 2'b01, 3'd1, 8'hB6},
    {4'b1000, 2'b00, 3'd0, 8'hB6}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive pins, then let three register stages plus margin settle
  task automatic step(input logic c, input logic h, input logic k, input logic d);
    @(negedge clk);
    csn = c; holdn = h; sck = k; sdi = d;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      step(1'b0, 1'b1, 1'b0, b[i]);
      step(1'b0, 1'b1, 1'b1, b[i]);
    end
    step(1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    int c0, d0, v0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    // R11 reset state
    chk("R11", "paused", int'(paused), 0);
    chk("R11", "oe", int'(oe), 0);
    chk("R11", "cnt", int'(cnt), 0);
    chk("R11", "word", int'(word), 0);

    // R1 R2 R3 R4 R5 R6 R7 via vector walk
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13]);
      chk("R2/R3 row", $sformatf("%0d paused", i), int'(paused), int'(VEC[i][12]));
      chk("R4 row", $sformatf("%0d oe", i), int'(oe), int'(VEC[i][11]));
      chk("R5/R6 row", $sformatf("%0d cnt", i), int'(cnt), int'(VEC[i][10:8]));
      chk("R7 row", $sformatf("%0d word", i), int'(word), int'(VEC[i][7:0]));
    end
    // R9 entry/exit pulse counts; R6 abort gives no exit pulse
    chk("R9", "enter pulses", n_enter, 3);
    chk("R6", "exit pulses", n_exit, 2);
    chk("R7", "word valid pulses", n_vld, 1);

    // R10 R7 enables while active, none while paused (R4)
    c0 = n_cap; d0 = n_drv;
    step(1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 1'b1, 1'b1);
      step(1'b0, 1'b1, 1'b0, 1'b1);
    end
    chk("R7", "cap enables", n_cap - c0, 3);
    chk("R10", "drive enables", n_drv - d0, 3);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2", "paused on low clock", int'(paused), 1);
    c0 = n_cap; d0 = n_drv;
    for (int i = 0; i < 2; i++) begin
      step(1'b0, 1'b0, 1'b1, 1'b1);
      step(1'b0, 1'b0, 1'b0, 1'b1);
    end
    chk("R4", "cap while paused", n_cap - c0, 0);
    chk("R4", "drive while paused", n_drv - d0, 0);
    chk("R5", "cnt frozen", int'(cnt), 3);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3", "resumed", int'(paused), 0);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R6", "cnt cleared on deselect", int'(cnt), 0);

    // R7 full word after clean selection
    v0 = n_vld;
    step(1'b0, 1'b1, 1'b0, 1'b0);
    send_byte(8'h5A);
    chk("R7", "word 5A", int'(word), 8'h5A);
    chk("R7", "cnt wrapped", int'(cnt), 0);
    chk("R7", "one valid", n_vld - v0, 1);
    step(1'b1, 1'b1, 1'b0, 1'b0);

    // R8 chip select low through reset
    @(negedge clk);
    csn = 1'b0; rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8", "oe before arming", int'(oe), 0);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R8", "no capture before arming", int'(cnt), 0);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8", "oe after arming", int'(oe), 1);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R8", "capture after arming", int'(cnt), 1);
    step(1'b1, 1'b1, 1'b0, 1'b0);

    // R9 no pulse wider than one cycle
    chk("R9", "multi-cycle pulses", n_long, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule